// File: doc/BRIEF.md
# Processor Trace Capture Unit

This block sits beside a processor's bus and decides, cycle by cycle, what goes into a 64-entry on-chip trace store. It has two modes. In flow mode (`mode_detail` low) it records the addresses of change-of-flow events: branch source, branch destination and exception vector. A branch source that repeats is dropped, but the comparator that detects repeats catches up one cycle late. In access mode (`mode_detail` high) it records every data or register access. Each of these entries holds the address, the data, an information byte giving size and direction, and a snapshot of a second core's program counter. An optional inclusive address window can narrow what is captured.

The store is circular. Once it has been filled, each new entry overwrites the oldest one. A read index selects an entry relative to the oldest entry still held, and the selected entry appears on the read port one clock later. A fill count shows how many entries are valid.

Top module: `trc_capture`

## Requirements
- R1: While `cap_en` is low nothing is written and `fill_count` does not change.
- R2: In flow mode at most one entry is written per cycle. When more than one strobe is high, vector wins over destination, and destination wins over source. Entry layout is [63:40] address, [39:24] data, [23:16] info, [15:0] snapshot PC. Flow entries carry info[7:6] = 01 for source, 10 for destination and 11 for vector, with info[5:0], data and PC all zero.
- R3: Destination and vector entries are stored every time, including exact repeats in consecutive cycles.
- R4: A source address equal to the last stored source address is dropped. There is one exception: if that previous source entry was written in the immediately preceding cycle and was not itself a repeat, the new one is stored. A source repeated back-to-back is therefore stored twice and then dropped.
- R5: Dropping `cap_en` forgets the last stored source, so the first source event after re-enable is always stored.
- R6: In access mode, cycles of kind 2 (data) and 3 (register) are captured, while kind 0 (free) and kind 1 (opcode fetch) are not. Flow strobes have no effect in access mode.
- R7: Access entries hold the address, the data, info = {2'b00, 4'b0, write, word} and `peer_pc`.
- R8: With `win_en` high, access entries are written only when `win_lo` <= address <= `win_hi`. With `win_en` low there is no address limit.
- R9: The store keeps the newest 64 entries, and `fill_count` saturates at 64.
- R10: `rd_idx` = 0 selects the oldest entry held. `rd_word` shows the selected entry one clock after `rd_idx` is applied.
- R11: After reset `fill_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable |
| mode_detail | input | 1 | 0 = flow mode, 1 = access mode |
| win_en | input | 1 | Address window enable (access mode) |
| win_lo | input | 24 | Inclusive window low bound |
| win_hi | input | 24 | Inclusive window high bound |
| cyc_kind | input | 2 | 0 free, 1 opcode fetch, 2 data, 3 register |
| bus_addr | input | 24 | Access or flow event address |
| bus_data | input | 16 | Access data |
| bus_word | input | 1 | 1 = word access, 0 = byte |
| bus_wr | input | 1 | 1 = write, 0 = read |
| cof_src | input | 1 | Branch source strobe |
| cof_dst | input | 1 | Branch destination strobe |
| cof_vec | input | 1 | Vector fetch strobe |
| peer_pc | input | 16 | Other core's program counter |
| rd_idx | input | 6 | Read index relative to the oldest entry |
| rd_word | output | 64 | Selected entry, one cycle after `rd_idx` |
| fill_count | output | 7 | Number of valid entries (0..64) |

## Verification
The bench drives a source address three times back-to-back and expects exactly two stored copies. A comparator updated too early would keep only one copy, and one that never updates would keep all three. It then interleaves a second source address and an idle gap to show that repeats are judged against the last stored source, not against the last event seen. Destination and vector repeats, and cycles with several strobes high at once, expose wrong priority or suppression leaking onto non-source entries. Window bounds are probed one address below, exactly at, and one above each edge, so an off-by-one comparison shows up. Overfilling the store by six entries shows whether the oldest-first read base moves on after wrap, and whether the fill count saturates.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    CYC_FREE = 2'd0,
    CYC_OPF  = 2'd1,
    CYC_DATA = 2'd2,
    CYC_REG  = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ENT_ACCESS = 2'd0,
    ENT_SRC    = 2'd1,
    ENT_DST    = 2'd2,
    ENT_VEC    = 2'd3
  } ent_kind_e;

  function automatic logic [7:0] info_byte(ent_kind_e k, logic wr, logic word);
    return {k, 4'b0000, wr, word};
  endfunction

  function automatic logic is_access(logic [1:0] kind);
    return kind[1];
  endfunction
endpackage

// File: rtl/trc_src_dedup.sv
module trc_src_dedup #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          src_req,
  input  logic [AW-1:0] src_addr,
  output logic          src_keep
);
  logic [AW-1:0] pend_q;
  logic          pend_v_q;
  logic          fresh_q;
  logic          same_as_pend;
  logic          store;

  assign same_as_pend = pend_v_q && (src_addr == pend_q);
  // the compare only bites once the last stored source has settled for a cycle
  assign src_keep = !(same_as_pend && !fresh_q);
  assign store    = src_req && src_keep;

  always_ff @(posedge clk) begin
    if (!rst_n || !cap_en) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      fresh_q  <= 1'b0;
    end else begin
      fresh_q <= store && !same_as_pend;
      if (store) begin
        pend_q   <= src_addr;
        pend_v_q <= 1'b1;
      end
    end
  end

  AST_DUP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && $past(store, 1) && $past(store, 2) &&
     src_addr == $past(src_addr, 1) && src_addr == $past(src_addr, 2)) |-> !src_keep); // R4

  AST_FIRST_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !$past(cap_en)) |-> src_keep); // R5
endmodule

// File: rtl/trc_select.sv
module trc_select
  import trc_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int PCW = 16,
  localparam int EW = AW + DW + 8 + PCW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           mode_detail,
  input  logic           win_en,
  input  logic [AW-1:0]  win_lo,
  input  logic [AW-1:0]  win_hi,
  input  logic [1:0]     cyc_kind,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_data,
  input  logic           bus_word,
  input  logic           bus_wr,
  input  logic           cof_src,
  input  logic           cof_dst,
  input  logic           cof_vec,
  input  logic [PCW-1:0] peer_pc,
  input  logic           src_keep,
  output logic           src_req,
  output logic           wr_en,
  output logic [EW-1:0]  wr_word
);
  logic      in_win;
  logic      access_hit;
  logic      vec_hit;
  logic      dst_hit;
  logic      flow_on;
  ent_kind_e flow_kind;

  assign in_win     = (bus_addr >= win_lo) && (bus_addr <= win_hi);
  assign access_hit = cap_en && mode_detail && is_access(cyc_kind) && (!win_en || in_win);
  assign flow_on    = cap_en && !mode_detail;
  assign vec_hit    = flow_on && cof_vec;
  assign dst_hit    = flow_on && cof_dst && !cof_vec;
  assign src_req    = flow_on && cof_src && !cof_dst && !cof_vec;
  assign wr_en      = access_hit || vec_hit || dst_hit || (src_req && src_keep);

  always_comb begin
    if (vec_hit)      flow_kind = ENT_VEC;
    else if (dst_hit) flow_kind = ENT_DST;
    else              flow_kind = ENT_SRC;
  end

  always_comb begin
    if (mode_detail)
      wr_word = {bus_addr, bus_data, info_byte(ENT_ACCESS, bus_wr, bus_word), peer_pc};
    else
      wr_word = {bus_addr, {DW{1'b0}}, info_byte(flow_kind, 1'b0, 1'b0), {PCW{1'b0}}};
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !wr_en); // R1

  AST_DST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !mode_detail && cof_dst) |-> wr_en); // R3

  AST_SKIP_FREE_OPF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_detail && (cyc_kind == CYC_FREE || cyc_kind == CYC_OPF)) |-> !wr_en); // R6

  AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_detail && win_en && wr_en) |-> (bus_addr >= win_lo && bus_addr <= win_hi)); // R8
endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter int EW    = 64,
  parameter int DEPTH = 64,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [EW-1:0] wr_word,
  input  logic [PTRW-1:0] rd_idx,
  output logic [EW-1:0] rd_word,
  output logic [PTRW:0] fill_count
);
  logic [EW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wr_ptr_q;
  logic            wrapped_q;
  logic [PTRW-1:0] oldest;
  logic [PTRW-1:0] rd_addr;

  assign oldest     = wrapped_q ? wr_ptr_q : '0;
  assign rd_addr    = oldest + rd_idx;
  assign fill_count = wrapped_q ? (PTRW+1)'(DEPTH) : {1'b0, wr_ptr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      wrapped_q <= 1'b0;
    end else if (wr_en) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (wr_ptr_q == PTRW'(DEPTH - 1)) wrapped_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_word <= '0;
    else        rd_word <= mem[rd_addr];
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_ptr_q == PTRW'($past(wr_ptr_q) + 1'b1)); // R9

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped_q |=> wrapped_q); // R9

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= (PTRW+1)'(DEPTH)); // R9
endmodule

// File: rtl/trc_capture.sv
module trc_capture #(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int PCW   = 16,
  parameter int DEPTH = 64,
  localparam int EW   = AW + DW + 8 + PCW,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            mode_detail,
  input  logic            win_en,
  input  logic [AW-1:0]   win_lo,
  input  logic [AW-1:0]   win_hi,
  input  logic [1:0]      cyc_kind,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_data,
  input  logic            bus_word,
  input  logic            bus_wr,
  input  logic            cof_src,
  input  logic            cof_dst,
  input  logic            cof_vec,
  input  logic [PCW-1:0]  peer_pc,
  input  logic [PTRW-1:0] rd_idx,
  output logic [EW-1:0]   rd_word,
  output logic [PTRW:0]   fill_count
);
  logic          src_req;
  logic          src_keep;
  logic          wr_en;
  logic [EW-1:0] wr_word;

  trc_src_dedup #(.AW(AW)) u_dedup (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .src_req(src_req), .src_addr(bus_addr), .src_keep(src_keep)
  );

  trc_select #(.AW(AW), .DW(DW), .PCW(PCW)) u_select (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_detail(mode_detail),
    .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi), .cyc_kind(cyc_kind),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_word(bus_word), .bus_wr(bus_wr),
    .cof_src(cof_src), .cof_dst(cof_dst), .cof_vec(cof_vec), .peer_pc(peer_pc),
    .src_keep(src_keep), .src_req(src_req), .wr_en(wr_en), .wr_word(wr_word)
  );

  trc_ring #(.EW(EW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .rd_idx(rd_idx), .rd_word(rd_word), .fill_count(fill_count)
  );

  AST_FILL_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cap_en) && $past(rst_n) |-> $stable(fill_count)); // R1
endmodule

// File: tb/trc_capture_tb.sv
`timescale 1ns/1ps
module trc_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0, mode_detail = 1'b0, win_en = 1'b0;
  logic [23:0] win_lo = '0, win_hi = '0, bus_addr = '0;
  logic [1:0]  cyc_kind = '0;
  logic [15:0] bus_data = '0, peer_pc = '0;
  logic        bus_word = 1'b0, bus_wr = 1'b0;
  logic        cof_src = 1'b0, cof_dst = 1'b0, cof_vec = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic [63:0] rd_word;
  logic [6:0]  fill_count;

  always #10 clk = ~clk;

  trc_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_detail(mode_detail),
    .win_en(win_en), .win_lo(win_lo), .win_hi(win_hi), .cyc_kind(cyc_kind),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_word(bus_word), .bus_wr(bus_wr),
    .cof_src(cof_src), .cof_dst(cof_dst), .cof_vec(cof_vec), .peer_pc(peer_pc),
    .rd_idx(rd_idx), .rd_word(rd_word), .fill_count(fill_count)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // configuration applied by the driver at its own edge
  logic        c_en = 1'b0, c_md = 1'b0, c_wen = 1'b0;
  logic [23:0] c_lo = '0, c_hi = '0;

  // scoreboard and reference state
  logic [63:0] exp_q[$];
  logic [23:0] m_last;
  bit          m_valid = 0;
  bit          m_fresh = 0;

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [63:0] e);
    exp_q.push_back(e);
    if (exp_q.size() > 64) void'(exp_q.pop_front());
  endtask

  // driver: one bus cycle per call, expected entries pushed to the queue
  task automatic step(logic [1:0] k, logic [23:0] a, logic [15:0] d, logic w, logic r,
                      logic s, logic ds, logic v, logic [15:0] pc);
    @(negedge clk);
    cap_en = c_en; mode_detail = c_md; win_en = c_wen; win_lo = c_lo; win_hi = c_hi;
    cyc_kind = k; bus_addr = a; bus_data = d; bus_word = w; bus_wr = r;
    cof_src = s; cof_dst = ds; cof_vec = v; peer_pc = pc;
    if (!c_en) begin
      m_valid = 0; m_fresh = 0;
    end else if (c_md) begin
      m_fresh = 0;
      if (k >= 2'd2 && (!c_wen || (a >= c_lo && a <= c_hi)))
        push({a, d, 2'b00, 4'b0000, r, w, pc});
    end else if (v) begin
      m_fresh = 0; push({a, 16'h0, 8'hC0, 16'h0});
    end else if (ds) begin
      m_fresh = 0; push({a, 16'h0, 8'h80, 16'h0});
    end else if (s) begin
      if (m_valid && !m_fresh && a == m_last) begin
        m_fresh = 0;
      end else begin
        push({a, 16'h0, 8'h40, 16'h0});
        m_fresh = !(m_valid && a == m_last);
        m_last = a; m_valid = 1;
      end
    end else begin
      m_fresh = 0;
    end
  endtask

  task automatic idle();
    step(2'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete(); m_valid = 0; m_fresh = 0;
    check64("R11 fill after reset", {57'h0, fill_count}, 64'd0);
  endtask

  // monitor: reads the store oldest first and pops the scoreboard
  task automatic drain(string tag);
    int n;
    idle();
    @(negedge clk);
    check64({tag, " fill_count"}, {57'h0, fill_count}, 64'(exp_q.size()));
    n = exp_q.size();
    for (int i = 0; i < n; i++) begin
      rd_idx = 6'(i);
      @(negedge clk);
      check64($sformatf("%s entry %0d (R10)", tag, i), rd_word, exp_q.pop_front());
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] held;
    do_reset();

    // flow mode: priority, repeats, late comparator
    c_en = 1; c_md = 0;
    step(0, 24'h123456, 16'hAAAA, 1, 1, 1, 0, 0, 16'h5555); // R4 stored
    step(0, 24'h123456, 16'h0, 0, 0, 1, 0, 0, 16'h0);       // R4 stored again
    step(0, 24'h123456, 16'h0, 0, 0, 1, 0, 0, 16'h0);       // R4 dropped
    step(0, 24'h000F00, 16'h0, 0, 0, 1, 0, 0, 16'h0);
    step(0, 24'h123456, 16'h0, 0, 0, 1, 0, 0, 16'h0);
    idle();
    step(0, 24'h123456, 16'h0, 0, 0, 1, 0, 0, 16'h0);       // R4 dropped after gap
    step(0, 24'hABCDEF, 16'h1, 0, 0, 0, 1, 0, 16'h1);       // R3
    step(0, 24'hABCDEF, 16'h1, 0, 0, 0, 1, 0, 16'h1);       // R3 repeat kept
    step(0, 24'hFFFFF0, 16'h2, 0, 0, 0, 0, 1, 16'h2);
    step(0, 24'hFFFFF0, 16'h2, 0, 0, 0, 0, 1, 16'h2);
    step(0, 24'h111111, 16'h3, 0, 0, 1, 1, 1, 16'h3);       // R2 vector wins
    step(0, 24'h222222, 16'h4, 0, 0, 1, 1, 0, 16'h4);       // R2 destination wins
    drain("R2/flow");

    // R1 disabled capture, then R5 re-enable
    @(negedge clk);
    held = fill_count;
    c_en = 0;
    step(2, 24'h123456, 16'h0, 0, 0, 1, 0, 0, 16'h0);
    step(0, 24'h123456, 16'h0, 0, 0, 0, 1, 0, 16'h0);
    step(0, 24'h123456, 16'h0, 0, 0, 0, 0, 1, 16'h0);
    idle();
    @(negedge clk);
    check64("R1 fill unchanged while off", {57'h0, fill_count}, {57'h0, held});
    do_reset();
    c_en = 1;
    step(0, 24'h00ABCD, 16'h0, 0, 0, 1, 0, 0, 16'h0);
    idle(); idle();
    c_en = 0; idle();
    c_en = 1;
    step(0, 24'h00ABCD, 16'h0, 0, 0, 1, 0, 0, 16'h0);       // R5 stored
    drain("R5");

    // access mode: kinds, info byte, snapshot
    do_reset();
    c_en = 1; c_md = 1;
    step(0, 24'h000010, 16'h1111, 1, 0, 0, 0, 0, 16'hA000); // R6 free skipped
    step(1, 24'h000020, 16'h2222, 1, 0, 0, 0, 0, 16'hA001); // R6 opfetch skipped
    step(2, 24'h000030, 16'h3333, 1, 0, 0, 0, 0, 16'hA002); // R7 word read
    step(3, 24'h000040, 16'h0044, 0, 1, 0, 0, 0, 16'hA003); // R7 byte write
    step(2, 24'h000050, 16'h0055, 0, 1, 0, 0, 0, 16'hA004);
    step(0, 24'h000060, 16'h6666, 0, 0, 1, 1, 1, 16'hA005); // R6 strobes ignored
    step(2, 24'h000070, 16'h7777, 1, 1, 1, 0, 0, 16'hA006);
    drain("R6/R7");

    // window bounds
    do_reset();
    c_en = 1; c_md = 1; c_wen = 1; c_lo = 24'h000100; c_hi = 24'h0001FF;
    step(2, 24'h0000FF, 16'h1, 1, 0, 0, 0, 0, 16'h1);       // R8 below
    step(2, 24'h000100, 16'h2, 1, 0, 0, 0, 0, 16'h2);       // R8 low edge
    step(3, 24'h0001FF, 16'h3, 0, 1, 0, 0, 0, 16'h3);       // R8 high edge
    step(2, 24'h000200, 16'h4, 1, 0, 0, 0, 0, 16'h4);       // R8 above
    step(2, 24'h000150, 16'h5, 1, 1, 0, 0, 0, 16'h5);
    c_wen = 0;
    step(2, 24'h000200, 16'h6, 1, 0, 0, 0, 0, 16'h6);       // R8 window off
    drain("R8");

    // wrap-around
    do_reset();
    c_en = 1; c_md = 1;
    for (int i = 0; i < 70; i++)
      step(2, 24'(i), 16'(i * 3), 1, 0, 0, 0, 0, 16'(i));
    drain("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule